// File: doc/BRIEF.md
# Configurable serial frame transmitter

The block turns one character per request into a serial frame on a single transmit line. Software-free and format-agnostic at build time, it takes the frame shape from run-time inputs: a character length of five to nine data bits, parity off, even or odd, and one or two stop bits. These give thirty legal formats. A character is offered on a valid/ready handshake. The format, mode and polarity are captured together with the character, so the whole frame is built from one consistent setting.

In asynchronous mode each bit lasts a fixed number of pulses of an external baud tick. In synchronous mode the block also drives a transfer clock at half the tick rate. A polarity input chooses whether the line changes on the rising or the falling transfer-clock edge. A busy flag covers the frame from the start bit to the end of the last stop bit. A new character can be taken in the final tick of a frame, so frames can follow each other with no idle gap.

Top module: `frame_tx`

## Requirements
- R1: In the clock cycle after a character is accepted (`valid_i` and `ready_o` both high at a rising clock edge), `tx_o` is low and `busy_o` is high. This start bit lasts exactly one bit time.
- R2: After the start bit, the data bits go out least significant bit first. The count is `len_code_i + 5`, so codes 0 to 4 give 5 to 9 bits, and codes 5 to 7 also give 9 bits.
- R3: Bits of `data_i` at or above the configured length are never sent and do not affect parity.
- R4: With `par_en_i` = 1, one parity bit follows the last data bit. With `par_odd_i` = 0 it is the XOR of the sent data bits, and with `par_odd_i` = 1 it is the inverse of that XOR. With `par_en_i` = 0 there is no parity bit.
- R5: One stop bit (`stop2_i` = 0) or two stop bits (`stop2_i` = 1) follow, each driven high.
- R6: While `busy_o` is low, `tx_o` is high and `ready_o` is high.
- R7: In asynchronous mode (`sync_i` = 0), each bit lasts `TICKS_PER_BIT` cycles in which `tick_i` is high. Without a tick, the line and the frame progress hold still.
- R8: In synchronous mode (`sync_i` = 1), each bit lasts two ticks. `xck_o` sits at `pol_i` when idle and at the inverse of `pol_i` during the first tick of each bit. The line changes only as `xck_o` leaves its idle level: on the rising edge for polarity 0 and on the falling edge for polarity 1.
- R9: `busy_o` stays high until the last stop bit ends. `ready_o` is high while busy only in the cycle where the last stop bit ends, and a character accepted there starts its start bit with no idle gap.
- R10: Format, mode, polarity and data are captured at acceptance. Changing these inputs during a frame does not alter that frame.
- R11: During reset, `tx_o` is high, `busy_o` is low and `xck_o` follows `pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | MAX_DATA | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be taken this cycle |
| len_code_i | input | 3 | Data length code, length = code + 5, saturating at 9 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when set, even otherwise |
| stop2_i | input | 1 | Two stop bits when set |
| sync_i | input | 1 | Synchronous mode with transfer clock |
| pol_i | input | 1 | Transfer clock idle level and edge choice |
| tick_i | input | 1 | Baud tick |
| tx_o | output | 1 | Serial line |
| xck_o | output | 1 | Transfer clock |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit and a 9-bit data path. It holds the tick high on every cycle, so each bit time falls on a known cycle and the frame can be read bit by bit at mid-bit. This makes every length code, including the saturating ones, every parity choice and both stop counts reachable in asynchronous mode with several data patterns. The same sweep runs in synchronous mode under both polarities. Format inputs are scrambled after each acceptance, and there are dedicated runs for a back-to-back frame and for a stalled tick.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int MIN_DATA = 5;

  typedef struct packed {
    logic [2:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
  } fmt_t;
endpackage

// File: rtl/frame_tx_build.sv
module frame_tx_build
  import frame_tx_pkg::*;
#(
  parameter int MAX_DATA = 9,
  parameter int FRAME_W  = MAX_DATA + 4,
  parameter int LEN_W    = $clog2(FRAME_W + 1)
) (
  input  logic [MAX_DATA-1:0] data_i,
  input  fmt_t                fmt_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [LEN_W-1:0]    len_o
);
  localparam logic [2:0] MAX_CODE = 3'(MAX_DATA - MIN_DATA);

  logic [LEN_W-1:0]    nb;
  logic [MAX_DATA-1:0] keep;
  logic                par_bit;

  assign nb = (fmt_i.len_code > MAX_CODE) ? LEN_W'(MAX_DATA)
                                          : LEN_W'(fmt_i.len_code) + LEN_W'(MIN_DATA);

  for (genvar i = 0; i < MAX_DATA; i++) begin : g_keep
    assign keep[i] = LEN_W'(i) < nb;
  end

  assign par_bit = ^(data_i & keep) ^ fmt_i.par_odd;

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++) begin
      if (keep[i]) frame_o[1+i] = data_i[i];
    end
    if (fmt_i.par_en) frame_o[LEN_W'(1) + nb] = par_bit;
    len_o = LEN_W'(2) + nb + LEN_W'(fmt_i.par_en) + LEN_W'(fmt_i.stop2);
  end
endmodule

// File: rtl/frame_tx_pace.sv
module frame_tx_pace #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic tick_i,
  input  logic sync_i,
  output logic bit_end_o,
  output logic first_half_o
);
  localparam int SUB_W = (TICKS_PER_BIT > 2) ? $clog2(TICKS_PER_BIT) : 1;

  logic [SUB_W-1:0] sub_q, last;

  // synchronous mode: two ticks per bit, one per transfer-clock half
  assign last         = sync_i ? SUB_W'(1) : SUB_W'(TICKS_PER_BIT - 1);
  assign bit_end_o    = active_i & tick_i & (sub_q == last);
  assign first_half_o = (sub_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sub_q <= '0;
    else if (start_i)            sub_q <= '0;
    else if (active_i && tick_i) sub_q <= bit_end_o ? '0 : sub_q + SUB_W'(1);
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_DATA      = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [2:0]          len_code_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                stop2_i,
  input  logic                sync_i,
  input  logic                pol_i,
  input  logic                tick_i,
  output logic                tx_o,
  output logic                xck_o,
  output logic                busy_o
);
  localparam int FRAME_W = MAX_DATA + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  fmt_t               fmt;
  logic [FRAME_W-1:0] frame, shreg_q;
  logic [LEN_W-1:0]   len, left_q;
  logic               busy_q, sync_q, pol_q;
  logic               accept, bit_end, first_half, last_bit;

  assign fmt = '{len_code: len_code_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};

  frame_tx_build #(.MAX_DATA(MAX_DATA), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_build (
    .data_i (data_i),
    .fmt_i  (fmt),
    .frame_o(frame),
    .len_o  (len)
  );

  frame_tx_pace #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_pace (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .active_i    (busy_q),
    .tick_i      (tick_i),
    .sync_i      (sync_q),
    .bit_end_o   (bit_end),
    .first_half_o(first_half)
  );

  assign last_bit = (left_q == LEN_W'(1));
  // take the next character in the final tick of the last stop bit
  assign ready_o  = ~busy_q | (bit_end & last_bit);
  assign accept   = valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shreg_q <= '1;
      left_q  <= '0;
      sync_q  <= 1'b0;
      pol_q   <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      shreg_q <= frame;
      left_q  <= len;
      sync_q  <= sync_i;
      pol_q   <= pol_i;
    end else if (bit_end) begin
      if (last_bit) busy_q <= 1'b0;
      shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      left_q  <= left_q - LEN_W'(1);
    end
  end

  assign tx_o   = busy_q ? shreg_q[0] : 1'b1;
  assign xck_o  = busy_q ? (pol_q ^ (sync_q & first_half)) : pol_i;
  assign busy_o = busy_q;
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic tick_i,
  input logic tx_o,
  input logic xck_o,
  input logic busy_o,
  input logic sync_q,
  input logic pol_q
);
  AST_IDLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o && ready_o);                                   // R6
  AST_START_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !tx_o && busy_o);                        // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(tx_o) && busy_o);                 // R7
  AST_SYNC_CHANGE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && sync_q && !$stable(tx_o) |-> xck_o != pol_q);         // R8
  AST_READY_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ready_o |-> tick_i);                                  // R9
endmodule

bind frame_tx frame_tx_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .ready_o(ready_o),
  .tick_i (tick_i),
  .tx_o   (tx_o),
  .xck_o  (xck_o),
  .busy_o (busy_o),
  .sync_q (sync_q),
  .pol_q  (pol_q)
);

// File: tb/frame_tx_bench.sv
`timescale 1ns/1ps
module frame_tx_bench;
  localparam int TPB = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o;
  logic [2:0] len_code_i = '0;
  logic       par_en_i = 1'b0, par_odd_i = 1'b0, stop2_i = 1'b0;
  logic       sync_i = 1'b0, pol_i = 1'b0, tick_i = 1'b1;
  logic       tx_o, xck_o, busy_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  always #4 clk_i = ~clk_i;

  frame_tx u_frame_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o),
    .len_code_i(len_code_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i), .stop2_i(stop2_i),
    .sync_i(sync_i), .pol_i(pol_i), .tick_i(tick_i), .tx_o(tx_o), .xck_o(xck_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] code, input logic pen, input logic s2);
    int nb = (code > 3'd4) ? 9 : int'(code) + 5;
    return 2 + nb + int'(pen) + int'(s2);
  endfunction

  function automatic logic [12:0] exp_bits(input logic [8:0] d, input logic [2:0] code,
                                           input logic pen, input logic podd);
    int nb = (code > 3'd4) ? 9 : int'(code) + 5;
    logic [12:0] v = '1;
    logic p = podd;
    v[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      v[1+i] = d[i];
      p ^= d[i];
    end
    if (pen) v[1+nb] = p;
    return v;
  endfunction

  // at a negedge: offer a character, accept it, then scramble inputs (R10)
  task automatic start(input logic [8:0] d, input logic [2:0] code, input logic pen,
                       input logic podd, input logic s2, input logic sy, input logic po,
                       input string req);
    data_i = d; len_code_i = code; par_en_i = pen; par_odd_i = podd;
    stop2_i = s2; sync_i = sy; pol_i = po; valid_i = 1'b1;
    check(ready_o === 1'b1, req, 32'(ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    data_i = ~d; len_code_i = ~code; par_en_i = ~pen; par_odd_i = ~podd;
    stop2_i = ~s2; sync_i = ~sy; pol_i = ~po;
  endtask

  // from the negedge after acceptance to the negedge of the frame's last cycle
  task automatic body(input logic sy, input logic po, input int n, input logic [12:0] exp);
    logic [12:0] got = '1;
    bit xck_bad = 0;
    if (!sy) begin
      repeat (TPB/2) @(negedge clk_i);
      for (int k = 0; k < n; k++) begin
        got[k] = tx_o;
        if (k < n-1) repeat (TPB) @(negedge clk_i);
      end
      repeat (TPB/2 - 1) @(negedge clk_i);
    end else begin
      for (int k = 0; k < n; k++) begin
        got[k] = tx_o;
        if (xck_o !== ~po) xck_bad = 1;
        @(negedge clk_i);
        if (xck_o !== po || tx_o !== got[k]) xck_bad = 1;
        if (k < n-1) @(negedge clk_i);
      end
      check(!xck_bad, "R8 transfer clock phase", 32'(xck_bad), 0);
    end
    check(got[0] === 1'b0, "R1 start bit", 32'(got[0]), 0);
    check(got === exp, "R2 R3 R4 R5 R10 frame bits", 32'(got), 32'(exp));
  endtask

  task automatic tail;
    check(busy_o === 1'b1, "R9 busy through last stop", 32'(busy_o), 1);
    check(ready_o === 1'b1, "R9 ready in final tick", 32'(ready_o), 1);
    @(negedge clk_i);
    check(busy_o === 1'b0 && tx_o === 1'b1, "R6 idle after frame", {busy_o, tx_o}, 32'b01);
  endtask

  task automatic frame(input logic [8:0] d, input logic [2:0] code, input logic pen,
                       input logic podd, input logic s2, input logic sy, input logic po);
    start(d, code, pen, podd, s2, sy, po, "R6 ready when idle");
    body(sy, po, exp_len(code, pen, s2), exp_bits(d, code, pen, podd));
    tail();
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  initial begin
    pol_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(tx_o === 1'b1 && busy_o === 1'b0, "R11 reset line", {tx_o, busy_o}, 32'b10);
    check(xck_o === 1'b1, "R11 reset clock follows polarity", 32'(xck_o), 1);
    pol_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(ready_o === 1'b1 && tx_o === 1'b1, "R6 idle after reset", {ready_o, tx_o}, 32'b11);

    // asynchronous: every length code, parity choice and stop count
    for (int code = 0; code < 8; code++)
      for (int pm = 0; pm < 3; pm++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int p = 0; p < 3; p++)
            frame(9'((p*181 + code*53 + pm*29 + s2*7 + 346) & 511), 3'(code),
                  pm != 0, pm == 2, s2 != 0, 1'b0, 1'b0);

    // R3: high data bits set, short length
    frame(9'h1E0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // synchronous: both polarities (R8)
    for (int po = 0; po < 2; po++)
      for (int code = 0; code < 5; code++)
        for (int pm = 0; pm < 3; pm++)
          for (int s2 = 0; s2 < 2; s2++)
            frame(9'((code*97 + pm*41 + s2*13 + po*200 + 85) & 511), 3'(code),
                  pm != 0, pm == 2, s2 != 0, 1'b1, 1'(po));

    // R9: back-to-back frames with no idle gap
    start(9'h0A5, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 ready when idle");
    body(1'b0, 1'b0, exp_len(3'd3, 1'b1, 1'b0), exp_bits(9'h0A5, 3'd3, 1'b1, 1'b1));
    start(9'h15C, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 ready at frame end");
    check(tx_o === 1'b0 && busy_o === 1'b1, "R9 next start bit without gap", {tx_o, busy_o}, 32'b01);
    body(1'b0, 1'b0, exp_len(3'd4, 1'b0, 1'b1), exp_bits(9'h15C, 3'd4, 1'b0, 1'b0));
    tail();

    // R7: no tick, no progress
    tick_i = 1'b0;
    start(9'h033, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 ready when idle");
    repeat (40) @(negedge clk_i);
    check(tx_o === 1'b0 && busy_o === 1'b1 && ready_o === 1'b0, "R7 stalled on missing tick",
          {tx_o, busy_o, ready_o}, 32'b010);
    tick_i = 1'b1;
    body(1'b0, 1'b0, exp_len(3'd1, 1'b1, 1'b1), exp_bits(9'h033, 3'd1, 1'b1, 1'b0));
    tail();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule